// File: doc/BRIEF.md
# Far Transfer Privilege Checker with Inward Stack Switch

This block judges a far CALL or JMP aimed either straight at a code segment or at a gate. It compares the current privilege level, the requester level in the selector's low two bits, the gate level and the target code segment attributes. Every request ends in exactly one of two ways: a fault with a kind and an error code, or a new code selector, instruction pointer, stack selector and stack pointer.

A CALL that moves inward through a gate takes its new stack from a per-level table of stack selectors and pointers. It checks that the new stack has room, then pushes the caller linkage one doubleword per memory beat. The caller parameters are copied along the way. A same-level CALL pushes only the return address on the caller stack. A JMP touches no memory.

Requests enter through a valid/ready pair. `req_ready` is high only while the sequencer is idle. Every request field must be held steady while `req_valid` is high, and it is captured on the edge where both are high. The memory port is a master with valid/ready back-pressure. A beat completes on an edge where `mem_valid` and `mem_ready` are both high. Until then, address, write enable and write data hold steady. Read data is taken in the completing cycle.

Top module: `gate_xfer_seq`

## Requirements
- R1: A direct transfer to a non-conforming segment succeeds only when target DPL equals CPL. Otherwise it gives fault kind 1 (general protection) with the error code equal to the selector with bits 1:0 cleared. The new code selector is {selector[15:2], CPL}.
- R2: A direct transfer or gate transfer to a conforming segment succeeds when target DPL ≤ CPL, and the CPL stays unchanged. A conforming target with DPL > CPL gives fault kind 1.
- R3: A gate transfer needs max(RPL, CPL) ≤ gate DPL. If that fails, the error code is the gate selector with bits 1:0 cleared. It also needs target DPL ≤ max(RPL, CPL) and target DPL ≤ CPL. If either fails, the error code is the gate destination selector with bits 1:0 cleared. Both failures give fault kind 1.
- R4: A JMP through a gate never changes the CPL. A non-conforming target of such a JMP must have DPL equal to CPL, or fault kind 1 is raised.
- R5: A CALL through a gate to a non-conforming target with DPL < CPL sets the new CPL to the target DPL. The new stack selector and base pointer come from the table entry for that level. Entry n sits at bits n*16 of `tss_ss` and bits n*32 of `tss_esp`.
- R6: On an inward call, the base pointer must be at least 4*(count+4). If it is smaller, the result is fault kind 3 (stack) with error code 0, and no memory beat is issued.
- R7: An inward call writes, in this order: the old SS zero-extended, the old ESP, the parameters, the old CS zero-extended, and the old EIP. Each write goes to the current pointer minus 4. The final ESP is base − 4*(count+4).
- R8: Parameters are read from the old stack at old ESP + 4*(count−1) down to old ESP, one read before each parameter write.
- R9: Under memory back-pressure, no beat is lost or repeated. A pending request keeps its address, direction and data.
- R10: A target that is not present gives fault kind 2 with the error code equal to the target selector with bits 1:0 cleared. The privilege checks of R1 to R4 take priority over it.
- R11: A same-level CALL writes the old CS and then the old EIP below the old ESP. The result keeps the old SS and has ESP = old ESP − 8. A successful JMP issues no memory beat and keeps the old SS:ESP.
- R12: `req_ready` is low from acceptance until the outcome. Each accepted request produces exactly one single-cycle pulse, either on `done` or on `fault`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle and able to accept |
| req_call | input | 1 | 1 = CALL, 0 = JMP |
| req_gate | input | 1 | 1 = selector names a gate |
| cpl | input | 2 | Current privilege level |
| sel | input | 16 | Far selector; bits 1:0 are RPL |
| direct_off | input | 32 | Offset for a direct transfer |
| gate_dpl | input | 2 | Gate privilege level |
| gate_dsel | input | 16 | Gate destination selector |
| gate_doff | input | 32 | Gate destination offset |
| gate_wc | input | WC_W | Parameter doublewords to copy |
| tgt_dpl | input | 2 | Target code segment DPL |
| tgt_conf | input | 1 | Target is conforming |
| tgt_exec | input | 1 | Target is executable |
| tgt_present | input | 1 | Target is present |
| tss_ss | input | 48 | Stack selectors for levels 0..2 |
| tss_esp | input | 96 | Stack pointers for levels 0..2 |
| old_ss | input | 16 | Caller stack selector |
| old_esp | input | 32 | Caller stack pointer |
| old_cs | input | 16 | Caller code selector |
| old_eip | input | 32 | Return offset |
| mem_valid | output | 1 | Memory beat requested |
| mem_ready | input | 1 | Memory accepts the beat |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | Success pulse |
| fault | output | 1 | Fault pulse |
| fault_kind | output | 2 | 1 GP, 2 not present, 3 stack |
| fault_err | output | 16 | Fault error code |
| new_cpl | output | 2 | Resulting privilege level |
| new_cs | output | 16 | Resulting code selector |
| new_eip | output | 32 | Resulting offset |
| new_ss | output | 16 | Resulting stack selector |
| new_esp | output | 32 | Resulting stack pointer |

## Verification
The bench builds the block with its default count width of five bits. This allows counts of 0 and 3, so both the bypass of the copy loop and repeated read/write pairs are reached. Inward calls target levels 0 and 1 from levels 3 and 2. One of them runs with a memory that stalls every third cycle. Every beat is logged and compared in order against addresses and data worked out from the stacking rule.

// File: rtl/gx_pkg.sv
package gx_pkg;
  localparam int DW    = 32;
  localparam int SW    = 16;
  localparam int PW    = 2;
  localparam int NLVL  = 3;
  localparam int NSLOT = 1 << PW;

  typedef enum logic [1:0] {
    FK_NONE = 2'd0,
    FK_GP   = 2'd1,
    FK_NP   = 2'd2,
    FK_SS   = 2'd3
  } fault_e;

  typedef enum logic [1:0] {
    XP_JMP    = 2'd0,
    XP_SAME   = 2'd1,
    XP_INWARD = 2'd2
  } path_e;
endpackage

// File: rtl/gx_priv_check.sv
module gx_priv_check
  import gx_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          is_call,
  input  logic          via_gate,
  input  logic [PW-1:0] cpl,
  input  logic [SW-1:0] sel,
  input  logic [PW-1:0] gate_dpl,
  input  logic [SW-1:0] gate_dsel,
  input  logic [PW-1:0] tgt_dpl,
  input  logic          tgt_conf,
  input  logic          tgt_exec,
  input  logic          tgt_present,
  output fault_e        fault,
  output logic [SW-1:0] err,
  output path_e         path,
  output logic [PW-1:0] new_cpl,
  output logic [SW-1:0] dest_sel
);
  logic [PW-1:0] rpl, eff;
  logic [SW-1:0] sel_clr, dsel_clr;
  logic          tgt_bad;

  assign rpl      = sel[PW-1:0];
  assign eff      = (rpl > cpl) ? rpl : cpl;
  assign sel_clr  = {sel[SW-1:PW], {PW{1'b0}}};
  assign dsel_clr = {gate_dsel[SW-1:PW], {PW{1'b0}}};
  assign dest_sel = via_gate ? gate_dsel : sel;

  // Level rule on the code segment itself (shared by both forms)
  always_comb begin
    if (tgt_conf)      tgt_bad = (tgt_dpl > cpl);
    else if (via_gate) tgt_bad = is_call ? (tgt_dpl > cpl) : (tgt_dpl != cpl);
    else               tgt_bad = (tgt_dpl != cpl);
  end

  always_comb begin
    fault   = FK_NONE;
    err     = '0;
    path    = XP_JMP;
    new_cpl = cpl;
    if (!via_gate) begin
      if (!tgt_exec || tgt_bad) begin
        fault = FK_GP; err = sel_clr;
      end else if (!tgt_present) begin
        fault = FK_NP; err = sel_clr;
      end else begin
        path = is_call ? XP_SAME : XP_JMP;
      end
    end else begin
      if (eff > gate_dpl) begin
        fault = FK_GP; err = sel_clr;
      end else if (!tgt_exec || (tgt_dpl > eff) || tgt_bad) begin
        fault = FK_GP; err = dsel_clr;
      end else if (!tgt_present) begin
        fault = FK_NP; err = dsel_clr;
      end else if (is_call && !tgt_conf && (tgt_dpl < cpl)) begin
        path    = XP_INWARD;
        new_cpl = tgt_dpl;
      end else begin
        path = is_call ? XP_SAME : XP_JMP;
      end
    end
  end

  // R3: an accepted gate transfer never lands less privileged than the gate
  a_r3_gate_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (via_gate && fault == FK_NONE) |-> (new_cpl <= gate_dpl));

  // R2: conforming targets keep the caller level
  a_r2_conf_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_conf && fault == FK_NONE) |-> (new_cpl == cpl));
endmodule

// File: rtl/gx_push_seq.sv
module gx_push_seq
  import gx_pkg::*;
#(
  parameter int WC_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  fault_e          dec_fault,
  input  logic [SW-1:0]   dec_err,
  input  path_e           dec_path,
  input  logic [PW-1:0]   dec_cpl,
  input  logic [SW-1:0]   dest_cs,
  input  logic [DW-1:0]   dest_eip,
  input  logic [WC_W-1:0] wc,
  input  logic [SW-1:0]   base_ss,
  input  logic [DW-1:0]   base_esp,
  input  logic [SW-1:0]   o_ss,
  input  logic [DW-1:0]   o_esp,
  input  logic [SW-1:0]   o_cs,
  input  logic [DW-1:0]   o_eip,
  output logic            idle,
  output logic            mem_valid,
  input  logic            mem_ready,
  output logic            mem_we,
  output logic [DW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  output logic            done,
  output logic            fault,
  output fault_e          fault_kind,
  output logic [SW-1:0]   fault_err,
  output logic [PW-1:0]   res_cpl,
  output logic [SW-1:0]   res_cs,
  output logic [DW-1:0]   res_eip,
  output logic [SW-1:0]   res_ss,
  output logic [DW-1:0]   res_esp
);
  localparam logic [DW-1:0] STEP  = DW'(4);
  localparam logic [DW-1:0] LINKS = DW'(4);

  typedef enum logic [2:0] {S_IDLE, S_SS, S_ESP, S_RD, S_WR, S_CS, S_EIP} st_e;

  st_e             st;
  logic [DW-1:0]   wp, rp, pbuf, k_esp, k_eip, need_b;
  logic [SW-1:0]   k_ss, k_cs;
  logic [WC_W-1:0] cnt;
  logic            beat;

  assign need_b    = (DW'(wc) + LINKS) << 2;
  assign idle      = (st == S_IDLE);
  assign mem_valid = (st != S_IDLE);
  assign mem_we    = (st != S_RD);
  assign mem_addr  = (st == S_RD) ? rp : (wp - STEP);
  assign beat      = mem_valid && mem_ready;

  always_comb begin
    case (st)
      S_SS:    mem_wdata = DW'(k_ss);
      S_ESP:   mem_wdata = k_esp;
      S_CS:    mem_wdata = DW'(k_cs);
      S_EIP:   mem_wdata = k_eip;
      default: mem_wdata = pbuf;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; done <= 1'b0; fault <= 1'b0;
      fault_kind <= FK_NONE; fault_err <= '0;
      res_cpl <= '0; res_cs <= '0; res_eip <= '0; res_ss <= '0; res_esp <= '0;
      wp <= '0; rp <= '0; pbuf <= '0; cnt <= '0;
      k_ss <= '0; k_esp <= '0; k_cs <= '0; k_eip <= '0;
    end else begin
      done  <= 1'b0;
      fault <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (dec_fault != FK_NONE) begin
            fault <= 1'b1; fault_kind <= dec_fault; fault_err <= dec_err;
          end else if (dec_path == XP_INWARD && base_esp < need_b) begin
            fault <= 1'b1; fault_kind <= FK_SS; fault_err <= '0;
          end else begin
            fault_kind <= FK_NONE; fault_err <= '0;
            res_cpl <= dec_cpl; res_cs <= dest_cs; res_eip <= dest_eip;
            k_ss <= o_ss; k_esp <= o_esp; k_cs <= o_cs; k_eip <= o_eip;
            cnt  <= wc;
            rp   <= o_esp + need_b - DW'(20);
            case (dec_path)
              XP_INWARD: begin res_ss <= base_ss; wp <= base_esp; st <= S_SS; end
              XP_SAME:   begin res_ss <= o_ss; wp <= o_esp; st <= S_CS; end
              default:   begin res_ss <= o_ss; res_esp <= o_esp; done <= 1'b1; end
            endcase
          end
        end
        S_SS:  if (beat) begin wp <= wp - STEP; st <= S_ESP; end
        S_ESP: if (beat) begin
          wp <= wp - STEP;
          st <= (cnt != '0) ? S_RD : S_CS;
        end
        S_RD:  if (beat) begin pbuf <= mem_rdata; st <= S_WR; end
        S_WR:  if (beat) begin
          wp  <= wp - STEP;
          rp  <= rp - STEP;
          cnt <= cnt - 1'b1;
          st  <= (cnt == WC_W'(1)) ? S_CS : S_RD;
        end
        S_CS:  if (beat) begin wp <= wp - STEP; st <= S_EIP; end
        S_EIP: if (beat) begin res_esp <= wp - STEP; done <= 1'b1; st <= S_IDLE; end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R9: a stalled beat keeps its request steady
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R12: one outcome, one cycle wide
  a_r12_exclusive: assert property (@(posedge clk) disable iff (!rst_n) !(done && fault));
  a_r12_single: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);

  // R6: stack faults carry a zero code
  a_r6_zero_code: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && fault_kind == FK_SS) |-> (fault_err == '0));
endmodule

// File: rtl/gate_xfer_seq.sv
module gate_xfer_seq
  import gx_pkg::*;
#(
  parameter int WC_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_call,
  input  logic               req_gate,
  input  logic [1:0]         cpl,
  input  logic [15:0]        sel,
  input  logic [31:0]        direct_off,
  input  logic [1:0]         gate_dpl,
  input  logic [15:0]        gate_dsel,
  input  logic [31:0]        gate_doff,
  input  logic [WC_W-1:0]    gate_wc,
  input  logic [1:0]         tgt_dpl,
  input  logic               tgt_conf,
  input  logic               tgt_exec,
  input  logic               tgt_present,
  input  logic [47:0]        tss_ss,
  input  logic [95:0]        tss_esp,
  input  logic [15:0]        old_ss,
  input  logic [31:0]        old_esp,
  input  logic [15:0]        old_cs,
  input  logic [31:0]        old_eip,
  output logic               mem_valid,
  input  logic               mem_ready,
  output logic               mem_we,
  output logic [31:0]        mem_addr,
  output logic [31:0]        mem_wdata,
  input  logic [31:0]        mem_rdata,
  output logic               done,
  output logic               fault,
  output logic [1:0]         fault_kind,
  output logic [15:0]        fault_err,
  output logic [1:0]         new_cpl,
  output logic [15:0]        new_cs,
  output logic [31:0]        new_eip,
  output logic [15:0]        new_ss,
  output logic [31:0]        new_esp
);
  fault_e        d_fault, f_kind;
  path_e         d_path;
  logic [SW-1:0] d_err, d_dsel, d_cs;
  logic [PW-1:0] d_cpl;
  logic [DW-1:0] d_eip;
  logic [SW-1:0] lvl_ss  [NSLOT];
  logic [DW-1:0] lvl_esp [NSLOT];
  logic          idle;

  for (genvar g = 0; g < NLVL; g++) begin : g_lvl
    assign lvl_ss[g]  = tss_ss[g*SW +: SW];
    assign lvl_esp[g] = tss_esp[g*DW +: DW];
  end
  for (genvar g = NLVL; g < NSLOT; g++) begin : g_pad
    assign lvl_ss[g]  = '0;
    assign lvl_esp[g] = '0;
  end

  gx_priv_check u_chk (
    .clk(clk), .rst_n(rst_n),
    .is_call(req_call), .via_gate(req_gate), .cpl(cpl), .sel(sel),
    .gate_dpl(gate_dpl), .gate_dsel(gate_dsel),
    .tgt_dpl(tgt_dpl), .tgt_conf(tgt_conf), .tgt_exec(tgt_exec), .tgt_present(tgt_present),
    .fault(d_fault), .err(d_err), .path(d_path), .new_cpl(d_cpl), .dest_sel(d_dsel)
  );

  assign d_cs  = {d_dsel[SW-1:PW], d_cpl};
  assign d_eip = req_gate ? gate_doff : direct_off;

  gx_push_seq #(.WC_W(WC_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(req_valid && idle),
    .dec_fault(d_fault), .dec_err(d_err), .dec_path(d_path), .dec_cpl(d_cpl),
    .dest_cs(d_cs), .dest_eip(d_eip), .wc(gate_wc),
    .base_ss(lvl_ss[d_cpl]), .base_esp(lvl_esp[d_cpl]),
    .o_ss(old_ss), .o_esp(old_esp), .o_cs(old_cs), .o_eip(old_eip),
    .idle(idle),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .done(done), .fault(fault), .fault_kind(f_kind), .fault_err(fault_err),
    .res_cpl(new_cpl), .res_cs(new_cs), .res_eip(new_eip), .res_ss(new_ss), .res_esp(new_esp)
  );

  assign req_ready  = idle;
  assign fault_kind = f_kind;
endmodule

// File: tb/gate_xfer_seq_tb.sv
module gate_xfer_seq_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic req_valid = 0, req_call, req_gate, tgt_conf, tgt_exec, tgt_present;
  logic [1:0] cpl, gate_dpl, tgt_dpl;
  logic [15:0] sel, gate_dsel, old_ss, old_cs;
  logic [31:0] direct_off, gate_doff, old_esp, old_eip;
  logic [4:0] gate_wc;
  logic [47:0] tss_ss;
  logic [95:0] tss_esp;
  logic mem_ready = 1'b1;
  logic [31:0] mem_rdata;
  logic req_ready, mem_valid, mem_we, done, fault;
  logic [31:0] mem_addr, mem_wdata, new_eip, new_esp;
  logic [1:0] fault_kind, new_cpl;
  logic [15:0] fault_err, new_cs, new_ss;

  gate_xfer_seq dut_i (.*);

  logic [31:0] mem [256];
  logic [31:0] wa [64], wd [64], ra [64];
  int wn = 0, rn = 0, cyc = 0, checks = 0, errors = 0;
  bit stall = 0, got_done, got_fault, ready_leak;

  assign mem_rdata = mem[mem_addr[9:2]];

  always @(negedge clk) begin
    cyc++;
    mem_ready <= !stall || (cyc % 3 != 0);
  end

  always @(posedge clk) begin
    if (rst_n && mem_valid && mem_ready) begin
      if (mem_we) begin
        mem[mem_addr[9:2]] = mem_wdata;
        if (wn < 64) begin wa[wn] = mem_addr; wd[wn] = mem_wdata; end
        wn++;
      end else begin
        if (rn < 64) ra[rn] = mem_addr;
        rn++;
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_up;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic base;
    req_call = 0; req_gate = 0; cpl = 2'd3; sel = 16'h0; direct_off = 32'h0;
    gate_dpl = 2'd3; gate_dsel = 16'h0008; gate_doff = 32'h0000_4000; gate_wc = 5'd0;
    tgt_dpl = 2'd3; tgt_conf = 0; tgt_exec = 1; tgt_present = 1;
    tss_ss = {16'h001A, 16'h0019, 16'h0010};
    tss_esp = {32'h0000_0200, 32'h0000_0280, 32'h0000_0300};
    old_ss = 16'h002B; old_esp = 32'h100; old_cs = 16'h0023; old_eip = 32'h1234_5678;
    stall = 0; wn = 0; rn = 0;
  endtask

  task automatic run_req;
    int n = 0;
    ready_leak = 0;
    @(negedge clk);
    req_valid = 1;
    do begin
      @(negedge clk);
      req_valid = 0;
      n++;
      if (!done && !fault && req_ready) ready_leak = 1;
    end while (!(done || fault) && n < 500);
    got_done = done; got_fault = fault;
  endtask

  task automatic t_reset;
    chk("R12 reset ready", 32'(req_ready), 1);
    chk("R12 reset done", 32'(done), 0);
    chk("R12 reset fault", 32'(fault), 0);
    chk("R9 reset mem_valid", 32'(mem_valid), 0);
  endtask

  task automatic t_direct;
    base(); cpl = 2'd2; sel = 16'h0031; tgt_dpl = 2'd2; direct_off = 32'hCAFE_0010;
    run_req();
    chk("R1 direct jmp done", 32'(got_done), 1);
    chk("R1 direct jmp cs", 32'(new_cs), 32'h0032);
    chk("R1 direct jmp eip", new_eip, 32'hCAFE_0010);
    chk("R11 jmp no beats", 32'(wn + rn), 0);
    chk("R11 jmp keeps esp", new_esp, 32'h100);
    base(); cpl = 2'd2; sel = 16'h0031; tgt_dpl = 2'd1;
    run_req();
    chk("R1 nonconf mismatch fault", 32'(got_fault), 1);
    chk("R1 nonconf kind", 32'(fault_kind), 1);
    chk("R1 nonconf err", 32'(fault_err), 32'h0030);
  endtask

  task automatic t_conforming;
    base(); cpl = 2'd2; sel = 16'h0031; tgt_dpl = 2'd1; tgt_conf = 1; req_call = 0;
    run_req();
    chk("R2 conf ok", 32'(got_done), 1);
    chk("R2 conf cpl kept", 32'(new_cpl), 2);
    chk("R2 conf cs", 32'(new_cs), 32'h0032);
    base(); cpl = 2'd2; sel = 16'h0031; tgt_dpl = 2'd3; tgt_conf = 1;
    run_req();
    chk("R2 conf outward kind", 32'(got_fault ? fault_kind : 2'd0), 1);
  endtask

  task automatic t_gate_rules;
    base(); req_gate = 1; req_call = 1; cpl = 2'd1; sel = 16'h004B; gate_dpl = 2'd2; tgt_dpl = 2'd0;
    run_req();
    chk("R3 rpl over gate kind", 32'(got_fault ? fault_kind : 2'd0), 1);
    chk("R3 rpl over gate err", 32'(fault_err), 32'h0048);
    base(); req_gate = 1; req_call = 1; cpl = 2'd0; sel = 16'h0052; gate_dpl = 2'd3;
    gate_dsel = 16'h000B; tgt_dpl = 2'd3;
    run_req();
    chk("R3 outward target kind", 32'(got_fault ? fault_kind : 2'd0), 1);
    chk("R3 outward target err", 32'(fault_err), 32'h0008);
    base(); req_gate = 1; req_call = 0; tgt_dpl = 2'd0;
    run_req();
    chk("R4 jmp inward kind", 32'(got_fault ? fault_kind : 2'd0), 1);
    chk("R4 jmp inward err", 32'(fault_err), 32'h0008);
    base(); req_gate = 1; req_call = 0; tgt_dpl = 2'd0; tgt_conf = 1;
    run_req();
    chk("R4 jmp conf ok", 32'(got_done), 1);
    chk("R4 jmp conf cpl", 32'(new_cpl), 3);
    chk("R4 jmp conf cs", 32'(new_cs), 32'h000B);
    chk("R4 jmp conf no beats", 32'(wn), 0);
  endtask

  task automatic t_present;
    base(); cpl = 2'd2; sel = 16'h0031; tgt_dpl = 2'd2; tgt_present = 0;
    run_req();
    chk("R10 np kind", 32'(got_fault ? fault_kind : 2'd0), 2);
    chk("R10 np err", 32'(fault_err), 32'h0030);
    base(); req_gate = 1; req_call = 1; cpl = 2'd1; sel = 16'h004B; gate_dpl = 2'd2; tgt_present = 0;
    run_req();
    chk("R10 gp before np", 32'(fault_kind), 1);
  endtask

  task automatic t_inward3;
    logic [31:0] exp_d [7];
    base(); req_gate = 1; req_call = 1; tgt_dpl = 2'd0; gate_wc = 5'd3; stall = 1;
    mem[8'h40] = 32'hA000_0000; mem[8'h41] = 32'hA111_1111; mem[8'h42] = 32'hA222_2222;
    exp_d = '{32'h2B, 32'h100, 32'hA222_2222, 32'hA111_1111, 32'hA000_0000, 32'h23, 32'h1234_5678};
    run_req();
    chk("R5 inward done", 32'(got_done), 1);
    chk("R5 inward cpl", 32'(new_cpl), 0);
    chk("R5 inward ss", 32'(new_ss), 32'h0010);
    chk("R5 inward cs", 32'(new_cs), 32'h0008);
    chk("R5 inward eip", new_eip, 32'h0000_4000);
    chk("R7 final esp", new_esp, 32'h2E4);
    chk("R9 write count", 32'(wn), 7);
    chk("R9 read count", 32'(rn), 3);
    for (int i = 0; i < 7; i++) begin
      chk($sformatf("R7 push %0d addr", i), wa[i], 32'h2FC - 32'(4 * i));
      chk($sformatf("R7 push %0d data", i), wd[i], exp_d[i]);
    end
    for (int i = 0; i < 3; i++)
      chk($sformatf("R8 read %0d addr", i), ra[i], 32'h108 - 32'(4 * i));
    chk("R12 busy not ready", 32'(ready_leak), 0);
    @(negedge clk);
    chk("R12 done single pulse", 32'(done), 0);
  endtask

  task automatic t_inward0;
    base(); req_gate = 1; req_call = 1; cpl = 2'd2; sel = 16'h0062; tgt_dpl = 2'd1;
    gate_dsel = 16'h0018;
    run_req();
    chk("R5 lvl1 ss", 32'(new_ss), 32'h0019);
    chk("R5 lvl1 cs", 32'(new_cs), 32'h0019);
    chk("R7 wc0 esp", new_esp, 32'h270);
    chk("R8 wc0 no reads", 32'(rn), 0);
    chk("R7 wc0 third push", wd[2], 32'h23);
    chk("R7 wc0 third addr", wa[2], 32'h274);
  endtask

  task automatic t_room;
    base(); req_gate = 1; req_call = 1; tgt_dpl = 2'd0; gate_wc = 5'd3;
    tss_esp = {32'h200, 32'h280, 32'h10};
    run_req();
    chk("R6 short kind", 32'(got_fault ? fault_kind : 2'd0), 3);
    chk("R6 short err", 32'(fault_err), 0);
    chk("R6 short no beats", 32'(wn + rn), 0);
  endtask

  task automatic t_same;
    base(); req_call = 1; cpl = 2'd2; sel = 16'h0030; tgt_dpl = 2'd2; direct_off = 32'h44;
    run_req();
    chk("R11 same count", 32'(wn), 2);
    chk("R11 same cs addr", wa[0], 32'hFC);
    chk("R11 same cs data", wd[0], 32'h23);
    chk("R11 same eip addr", wa[1], 32'hF8);
    chk("R11 same eip data", wd[1], 32'h1234_5678);
    chk("R11 same esp", new_esp, 32'hF8);
    chk("R11 same ss", 32'(new_ss), 32'h2B);
  endtask

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_up();
      end
    join_none
  end

  initial begin
    base();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_direct();
    t_conforming();
    t_gate_rules();
    t_present();
    t_inward3();
    t_inward0();
    t_room();
    t_same();
    repeat (3) @(negedge clk);
    finish_up();
  end
endmodule